// File: doc/BRIEF.md
# Password-Gated Pin Write Lock

This block guards the register file of a banked general-purpose I/O controller against stray writes. It keeps one lock word per bank, with one bit per pin. A set bit means the pin is locked, and the neighbouring register logic may not change that pin's configuration, output or interrupt state. The block drives a flat write-allowed vector, one bit per pin, and that logic gates its own write strobes with it.

A lock word cannot be changed by a plain store. Software first writes a fixed 32-bit key to a single global key register. That arms the block for exactly one following bus write. If that write targets a bank's lock word, the word takes the written data. Any other write uses up the arming without effect. Idle bus cycles do not count as writes. Lock words can be read at any time through the same register bus.

Top module: `pin_lock_gate`

## Requirements
- R1: After a synchronous active-low reset, every lock bit is 1, every write-allowed bit is 0, and the block is not armed.
- R2: A write of value 0x00A5A501 to byte address 0x520 arms the block. The key write itself changes no lock word.
- R3: While armed, a write to byte address 0x500 + 4*b (b below the bank count) loads the full 32-bit write data into lock word b, visible from the next cycle.
- R4: A write to a lock word address while not armed leaves every lock word unchanged.
- R5: A write to any address other than the key register, including an unmapped one, disarms the block and changes no lock word.
- R6: A write to the key address with any value other than 0x00A5A501 leaves the block disarmed.
- R7: Arming covers one lock write only; a second lock write without a new key write is ignored.
- R8: Reads are combinational. rdata shows lock word b at address 0x500 + 4*b whether or not the block is armed, and 0 at every other address, including the key address.
- R9: Write-allowed bit b*32 + i is the inverse of bit i of lock word b.
- R10: Cycles with the write enable low neither arm nor disarm the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_wr_ok | output | 256 | Per-pin write permission, 1 = writes allowed |

## Verification
The bench goes after the ways the arming can leak. A key value off by one bit must not arm. A write to an unrelated address placed between key and lock write must disarm, or a design that only disarms on lock writes would accept a protected update. A second lock write after one key write must be rejected, or the arming would be sticky. Idle cycles between key and lock write must keep the arming, or a design counting cycles instead of writes would reject legal updates. A reset between key and lock write must clear the arming. Reads of unmapped addresses and of the key register must return zero. The write-allowed slice of a bank must track the inverse of its lock word.

// File: rtl/pin_lock_pkg.sv
// Package: shared word type and default constants of the pin write lock.
// Assumes 32 pins per bank, matching the bus data width.
package pin_lock_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
    localparam word_t DEF_KEY      = 32'h00A5_A501;
    localparam int    DEF_KEY_ADDR = 'h520;
    localparam int    DEF_LOCK_LO  = 'h500;
endpackage

// File: rtl/key_arm.sv
// Module: one-shot arming flag driven by key-register writes.
// Assumes the caller decodes address and key value; any bus write
// re-evaluates the flag, idle cycles hold it.
module key_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic key_addr_hit,
    input  logic key_data_ok,
    output logic armed
);
    // Arm on a correct key write, drop on any other write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (wr_en)
            armed <= key_addr_hit && key_data_ok;
    end

    a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_addr_hit && key_data_ok) |=> armed);
    a_r5_other_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(key_addr_hit && key_data_ok)) |=> !armed);
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(armed));
endmodule

// File: rtl/lock_bank.sv
// Module: one bank's lock word. Loads only on a selected write while armed.
// Assumes sel is already qualified by the bus write strobe.
module lock_bank #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            armed,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] lock_q
);
    // Hold the lock word; reset locks every pin.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= '1;
        else if (sel && armed)
            lock_q <= wdata;
    end

    a_r3_armed_load: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && armed) |=> (lock_q == $past(wdata)));
    a_r4_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && armed) |=> $stable(lock_q));
endmodule

// File: rtl/pin_lock_gate.sv
// Module: top of the password-gated per-pin write lock.
// Decodes the key register and the per-bank lock words on a simple
// register bus, returns lock words on reads and drives a write-allowed
// bit per pin. Assumes word-aligned accesses; misaligned ones are unmapped.
module pin_lock_gate
    import pin_lock_pkg::*;
#(
    parameter int    NUM_BANKS = 8,
    parameter int    ADDR_W    = 12,
    parameter int    KEY_ADDR  = DEF_KEY_ADDR,
    parameter int    LOCK_LO   = DEF_LOCK_LO,
    parameter word_t KEY_VAL   = DEF_KEY
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    output logic [WORD_W-1:0]          bus_rdata,
    output logic [NUM_BANKS*WORD_W-1:0] pin_wr_ok
);
    localparam int PINS   = WORD_W;
    localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(KEY_ADDR);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(LOCK_LO);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(LOCK_LO + 4 * NUM_BANKS);

    logic              armed;
    logic              key_hit;
    logic              lock_hit;
    logic [ADDR_W-1:0] offs;
    logic [BIDX_W-1:0] bidx;
    logic [PINS-1:0]   lock_w [NUM_BANKS];

    // Decode the key register and the lock-word window.
    always_comb begin
        offs     = bus_addr - A_LO;
        bidx     = offs[2 +: BIDX_W];
        key_hit  = (bus_addr == A_KEY);
        lock_hit = (bus_addr >= A_LO) && (bus_addr < A_HI) &&
                   (bus_addr[1:0] == 2'b00);
    end

    key_arm u_arm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bus_we),
        .key_addr_hit (key_hit),
        .key_data_ok  (bus_wdata == KEY_VAL),
        .armed        (armed)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = bus_we && lock_hit && (bidx == BIDX_W'(b));
        lock_bank #(.PINS(PINS)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (sel),
            .armed  (armed),
            .wdata  (bus_wdata),
            .lock_q (lock_w[b])
        );
        assign pin_wr_ok[b*PINS +: PINS] = ~lock_w[b];
    end

    // Read mux: lock word of the addressed bank, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (lock_hit && (bidx == BIDX_W'(b)))
                bus_rdata = lock_w[b];
    end

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_hit |-> (bus_rdata == '0));
endmodule

// File: tb/sim_pin_lock_gate.sv
// Bench: vector table of write-then-read steps, then directed tests.
module sim_pin_lock_gate;
    localparam int NB = 8;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NB*32-1:0]  pin_wr_ok;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pin_lock_gate u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_wr_ok(pin_wr_ok)
    );

    localparam logic [31:0] KEY = 32'h00A5_A501;
    // {req, we, waddr, wdata, raddr, expected rdata}
    localparam int NV = 12;
    localparam logic [NV-1:0][4+1+12+32+12+32-1:0] VEC = {
        {4'd4,  1'b1, 12'h500, 32'h0000_0000, 12'h500, 32'hFFFF_FFFF}, // R4
        {4'd2,  1'b1, 12'h520, KEY,           12'h500, 32'hFFFF_FFFF}, // R2
        {4'd3,  1'b1, 12'h504, 32'h1234_5678, 12'h504, 32'h1234_5678}, // R3
        {4'd7,  1'b1, 12'h504, 32'h0000_0000, 12'h504, 32'h1234_5678}, // R7
        {4'd6,  1'b1, 12'h520, 32'h00A5_A500, 12'h504, 32'h1234_5678}, // R6
        {4'd6,  1'b1, 12'h504, 32'h0000_0000, 12'h504, 32'h1234_5678}, // R6
        {4'd2,  1'b1, 12'h520, KEY,           12'h51C, 32'hFFFF_FFFF}, // R2
        {4'd5,  1'b1, 12'h100, 32'h0000_0000, 12'h51C, 32'hFFFF_FFFF}, // R5
        {4'd5,  1'b1, 12'h51C, 32'h0000_0000, 12'h51C, 32'hFFFF_FFFF}, // R5
        {4'd2,  1'b1, 12'h520, KEY,           12'h51C, 32'hFFFF_FFFF}, // R2
        {4'd3,  1'b1, 12'h51C, 32'hA5A5_0F0F, 12'h51C, 32'hA5A5_0F0F}, // R3
        {4'd8,  1'b0, 12'h000, 32'h0000_0000, 12'h520, 32'h0000_0000}  // R8
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input int req, input logic [11:0] a, input logic [31:0] exp);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every bank and of the write-allowed vector
        for (int b = 0; b < NB; b++) rd_check(1, 12'h500 + 12'(4*b), 32'hFFFF_FFFF);
        checks++;
        if (pin_wr_ok !== '0) begin
            errors++;
            $display("FAIL R1 actual %h expected 0", pin_wr_ok);
        end
        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [4+1+12+32+12+32-1:0] v;
            v = VEC[NV-1-i];
            if (v[88]) wr(v[87:76], v[75:44]);
            else @(negedge clk);
            rd_check(int'(v[92:89]), v[43:32], v[31:0]);
        end
        // R9: write-allowed slices follow inverted lock words
        checks++;
        if (pin_wr_ok[63:32] !== ~32'h1234_5678 || pin_wr_ok[255:224] !== ~32'hA5A5_0F0F
            || pin_wr_ok[31:0] !== 32'h0) begin
            errors++;
            $display("FAIL R9 actual %h expected slices inverted", pin_wr_ok);
        end
        // R10: idle cycles between key and lock write keep the arming
        wr(12'h520, KEY);
        repeat (5) @(negedge clk);
        wr(12'h508, 32'h0000_0000);
        rd_check(10, 12'h508, 32'h0000_0000);
        checks++;
        if (pin_wr_ok[95:64] !== 32'hFFFF_FFFF) begin
            errors++;
            $display("FAIL R9 actual %h expected ffffffff", pin_wr_ok[95:64]);
        end
        // R8: misaligned and out-of-window reads return zero, readable unarmed
        rd_check(8, 12'h509, 32'h0);
        rd_check(8, 12'h600, 32'h0);
        rd_check(8, 12'h504, 32'h1234_5678);
        // R5: write to an unmapped misaligned address disarms
        wr(12'h520, KEY);
        wr(12'h50A, 32'h0);
        wr(12'h50C, 32'h0);
        rd_check(5, 12'h50C, 32'hFFFF_FFFF);
        // R1: reset between key and lock write clears arming and locks
        wr(12'h520, KEY);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_check(1, 12'h508, 32'hFFFF_FFFF);
        wr(12'h510, 32'h0);
        rd_check(1, 12'h510, 32'hFFFF_FFFF);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule